// File: doc/BRIEF.md
# Keyed-Command Independent Watchdog

This block is a watchdog whose counting logic runs from a slow, free-running clock that has no relation to the bus clock. A 12-bit down-counter advances once per prescaler tick. The prescaler divides the slow clock by a power of two between 4 and 256. When the counter steps from one to zero, the block issues a reset request that lasts one slow-clock cycle. After that, the next tick reloads the counter and counting continues.

Software controls the block from the bus clock through a 16-bit command port that acts only on key values. One key starts the watchdog. Once started, it cannot be stopped short of a reset. A second key reloads the counter and also locks the configuration. A third key opens the prescaler and reload registers for writing, and any other key closes them again. An accepted configuration write is carried into the slow domain by a handshake, and a busy flag for each register stays high until the transfer is finished. A strap input makes the watchdog start by itself when it leaves reset.

Top module: `wdt_keyed_watchdog`

## Requirements
- R1: The counter decreases by one on each prescaler tick. With divider code c, a tick occurs every 4<<c slow-clock cycles for c from 0 to 5, and every 256 cycles for codes 6 and 7. The divider code is 0 after reset.
- R2: When the counter steps from 1 to 0, `reset_req` is high for exactly one slow-clock cycle, and `wdt_count` reads 0 in that cycle. The next tick loads the reload value, so consecutive requests are (reload+1)×ratio slow cycles apart.
- R3: Command key 0xCCCC sets `wdt_running` and loads the counter from the reload value. Until started, the counter holds its value and `reset_req` stays low. Once set, `wdt_running` stays set until reset.
- R4: When `hw_start` is 1 during reset, `wdt_running` rises on the first slow-clock edge after reset with no command, and the count starts at 0xFFF.
- R5: Command key 0xAAAA loads the counter from the reload value and restarts the prescaler phase, so the next request comes reload×ratio slow cycles after the load. It also locks the configuration registers.
- R6: Command key 0x5555 unlocks the configuration registers. Any other key written locks them. They are locked after reset.
- R7: A write to the divider or reload register is ignored while the registers are locked, or while that register's busy flag is high. An ignored write does not raise the busy flag and does not change the ratio or the timeout.
- R8: An accepted write raises the matching busy flag (`div_busy` or `rld_busy`) one bus cycle after the write. The flag falls once the new value has been taken over in the slow domain.
- R9: The reload value resets to 0xFFF and the counter resets to 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Free-running slow counter clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| hw_start | input | 1 | Strap: start automatically after reset (static) |
| cmd_we | input | 1 | Command write strobe |
| cmd_key | input | 16 | Command key value |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | 3 | Divider code |
| rld_we | input | 1 | Reload write strobe |
| rld_wdata | input | 12 | Reload value |
| div_busy | output | 1 | Divider update in flight (bus domain) |
| rld_busy | output | 1 | Reload update in flight (bus domain) |
| wdt_running | output | 1 | Watchdog started (slow domain) |
| wdt_count | output | 12 | Current counter value (slow domain) |
| reset_req | output | 1 | One-cycle reset request (slow domain) |

## Verification
The assertions check several rules on every cycle. The request pulse is never longer than one cycle and is only raised at a count of zero. No request appears before start, and a started watchdog never stops. The lock follows the last key written. The bus-side registers hold still while their busy flag is high, and a busy flag only rises after an unlocked write. The exact request periods for every divider code, the phase reset caused by a feed, the strap start, and the fact that rejected writes leave the timeout unchanged all depend on counting slow-clock cycles across the two unrelated clocks. Only the bench scenarios show those.

// File: rtl/wdt_pkg.sv
// Package: command keys and transfer-channel indices shared by the watchdog.
// Assumes a 16-bit command port.
package wdt_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;

    localparam int NUM_CH   = 4;
    localparam int CH_DIV   = 0;
    localparam int CH_RLD   = 1;
    localparam int CH_FEED  = 2;
    localparam int CH_START = 3;
endpackage

// File: rtl/wdt_sync.sv
// Module: multi-flop synchronizer for a single level signal.
// Assumes STAGES >= 2 and that the input is a level, not a pulse.
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_handshake.sv
// Module: toggle request/acknowledge crossing from a source to a destination clock.
// A launch that arrives while busy is dropped. The destination gets a one-cycle strobe.
// Assumes the source holds any related data stable while busy is high.
module wdt_handshake #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic launch,
    output logic busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic strobe
);
    logic req_tgl, ack_seen, req_seen, req_last;

    // flip the request level for each accepted launch
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)            req_tgl <= 1'b0;
        else if (launch && !busy)  req_tgl <= ~req_tgl;
    end

    wdt_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(req_last), .q(ack_seen)
    );

    assign busy = req_tgl ^ ack_seen;

    wdt_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_seen)
    );

    // remember the last request level seen; this doubles as the acknowledge
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) req_last <= 1'b0;
        else            req_last <= req_seen;
    end

    assign strobe = req_seen ^ req_last;
endmodule

// File: rtl/wdt_prescaler.sv
// Module: power-of-two tick generator for the slow domain.
// The ratio is 2^(MIN_SHIFT+code), clamped to 2^MAX_SHIFT.
// Uses a >= compare, so a ratio that shrinks mid-count ends the current period at once.
module wdt_prescaler #(
    parameter int DIV_W     = 3,
    parameter int MIN_SHIFT = 2,
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);
    localparam int PRE_W = MAX_SHIFT;

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] limit;
    int unsigned      shamt;

    // terminal phase value for the selected code
    always_comb begin
        shamt = MIN_SHIFT + int'(code);
        if (shamt > MAX_SHIFT) shamt = MAX_SHIFT;
        limit = PRE_W'((32'd1 << shamt) - 32'd1);
    end

    assign tick = run && !clear && (phase >= limit);

    // advance the phase; restart it on clear, when idle, or after a tick
    always_ff @(posedge clk) begin
        if (!rst_n)                     phase <= '0;
        else if (clear || !run || tick) phase <= '0;
        else                            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/wdt_downcount.sv
// Module: watchdog down-counter with load.
// Stepping 1 -> 0 raises a registered one-cycle hit. A tick at 0 reloads the counter.
module wdt_downcount #(
    parameter int               CNT_W = 12,
    parameter logic [CNT_W-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    // count down, reload on command or after reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= INIT;
        else if (load)             count <= load_val;
        else if (tick)             count <= (count == '0) ? load_val : count - 1'b1;
    end

    // flag the step from one to zero
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= tick && !load && (count == CNT_W'(1));
    end
endmodule

// File: rtl/wdt_keyed_watchdog.sv
// Module: keyed-command watchdog. Bus-side command/configuration logic plus a
// slow-domain prescaler and counter.
// Assumes hw_start is static. Each reset is synchronous to its own clock, and
// both resets are applied together.
module wdt_keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int DIV_W       = 3,
    parameter int MIN_SHIFT   = 2,
    parameter int MAX_SHIFT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             hw_start,
    input  logic             cmd_we,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    output logic             div_busy,
    output logic             rld_busy,
    output logic             wdt_running,
    output logic [CNT_W-1:0] wdt_count,
    output logic             reset_req
);
    localparam logic [CNT_W-1:0] RLD_INIT = '1;

    // bus domain state
    logic             unlocked;
    logic [DIV_W-1:0] div_reg;
    logic [CNT_W-1:0] rld_reg;
    logic [NUM_CH-1:0] launch, busy, stb;
    logic             div_ok, rld_ok;

    assign div_ok = div_we && unlocked && !busy[CH_DIV];
    assign rld_ok = rld_we && unlocked && !busy[CH_RLD];

    // the last key written decides the lock: only the open key unlocks
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)  unlocked <= 1'b0;
        else if (cmd_we) unlocked <= (cmd_key == KEY_OPEN);
    end

    // accept configuration writes only when unlocked and no transfer is in flight
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            div_reg <= '0;
            rld_reg <= RLD_INIT;
        end else begin
            if (div_ok) div_reg <= div_wdata;
            if (rld_ok) rld_reg <= rld_wdata;
        end
    end

    // one launch per crossing channel
    always_comb begin
        launch           = '0;
        launch[CH_DIV]   = div_ok;
        launch[CH_RLD]   = rld_ok;
        launch[CH_FEED]  = cmd_we && (cmd_key == KEY_FEED);
        launch[CH_START] = cmd_we && (cmd_key == KEY_START);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_xfer
        wdt_handshake #(.STAGES(SYNC_STAGES)) u_hs (
            .src_clk  (bus_clk),
            .src_rst_n(bus_rst_n),
            .launch   (launch[ch]),
            .busy     (busy[ch]),
            .dst_clk  (slow_clk),
            .dst_rst_n(slow_rst_n),
            .strobe   (stb[ch])
        );
    end

    assign div_busy = busy[CH_DIV];
    assign rld_busy = busy[CH_RLD];

    // slow domain state
    logic [DIV_W-1:0] div_s;
    logic [CNT_W-1:0] rld_s;
    logic             started, tick, load;

    // take over configuration values when their transfer strobes
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            div_s <= '0;
            rld_s <= RLD_INIT;
        end else begin
            if (stb[CH_DIV]) div_s <= div_reg;
            if (stb[CH_RLD]) rld_s <= rld_reg;
        end
    end

    // start from the strap or the start key; only reset clears it
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n)                    started <= 1'b0;
        else if (hw_start || stb[CH_START]) started <= 1'b1;
    end

    assign load = stb[CH_FEED] || (stb[CH_START] && !started);

    wdt_prescaler #(.DIV_W(DIV_W), .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)) u_pre (
        .clk  (slow_clk),
        .rst_n(slow_rst_n),
        .run  (started),
        .clear(load),
        .code (div_s),
        .tick (tick)
    );

    wdt_downcount #(.CNT_W(CNT_W), .INIT(RLD_INIT)) u_cnt (
        .clk     (slow_clk),
        .rst_n   (slow_rst_n),
        .load    (load),
        .load_val(rld_s),
        .tick    (tick),
        .count   (wdt_count),
        .hit     (reset_req)
    );

    assign wdt_running = started;
endmodule

// File: rtl/wdt_keyed_watchdog_chk.sv
// Checker: cycle-level rules for the keyed watchdog, attached by bind.
module wdt_keyed_watchdog_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DIV_W = 3
) (
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             slow_clk,
    input logic             slow_rst_n,
    input logic             cmd_we,
    input logic [KEY_W-1:0] cmd_key,
    input logic             div_we,
    input logic             rld_we,
    input logic             unlocked,
    input logic [DIV_W-1:0] div_reg,
    input logic [CNT_W-1:0] rld_reg,
    input logic             div_busy,
    input logic             rld_busy,
    input logic             wdt_running,
    input logic [CNT_W-1:0] wdt_count,
    input logic             reset_req
);
    AST_PULSE_SINGLE: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        reset_req |=> !reset_req); // R2
    AST_PULSE_AT_ZERO: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        reset_req |-> (wdt_count == '0)); // R2
    AST_IDLE_NO_REQ: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !wdt_running |-> !reset_req); // R3
    AST_NEVER_STOPS: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        wdt_running |=> wdt_running); // R3
    AST_OPEN_KEY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (cmd_we && cmd_key == KEY_OPEN) |=> unlocked); // R6
    AST_OTHER_KEY_LOCKS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (cmd_we && cmd_key != KEY_OPEN) |=> !unlocked); // R6
    AST_DIV_HELD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        div_busy |=> $stable(div_reg)); // R7
    AST_RLD_HELD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        rld_busy |=> $stable(rld_reg)); // R7
    AST_DIV_ACCEPT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(div_busy) |-> $past(div_we && unlocked)); // R8
    AST_RLD_ACCEPT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(rld_busy) |-> $past(rld_we && unlocked)); // R8
endmodule

bind wdt_keyed_watchdog wdt_keyed_watchdog_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .slow_clk   (slow_clk),
    .slow_rst_n (slow_rst_n),
    .cmd_we     (cmd_we),
    .cmd_key    (cmd_key),
    .div_we     (div_we),
    .rld_we     (rld_we),
    .unlocked   (unlocked),
    .div_reg    (div_reg),
    .rld_reg    (rld_reg),
    .div_busy   (div_busy),
    .rld_busy   (rld_busy),
    .wdt_running(wdt_running),
    .wdt_count  (wdt_count),
    .reset_req  (reset_req)
);

// File: tb/wdt_keyed_watchdog_bench.sv
`timescale 1ns/100ps
module wdt_keyed_watchdog_bench;
    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        hw_start = 1'b0;
    logic        cmd_we = 1'b0, div_we = 1'b0, rld_we = 1'b0;
    logic [15:0] cmd_key = '0;
    logic [2:0]  div_wdata = '0;
    logic [11:0] rld_wdata = '0;
    logic        div_busy, rld_busy, wdt_running, reset_req;
    logic [11:0] wdt_count;

    int checks = 0;
    int errors = 0;

    always #10   bus_clk  = ~bus_clk;   // 50 MHz
    always #36.3 slow_clk = ~slow_clk;  // unrelated slow clock

    wdt_keyed_watchdog u_wdt_keyed_watchdog (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .hw_start(hw_start), .cmd_we(cmd_we), .cmd_key(cmd_key), .div_we(div_we),
        .div_wdata(div_wdata), .rld_we(rld_we), .rld_wdata(rld_wdata), .div_busy(div_busy),
        .rld_busy(rld_busy), .wdt_running(wdt_running), .wdt_count(wdt_count), .reset_req(reset_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    task automatic do_reset(input logic strap);
        hw_start   = strap;
        bus_rst_n  = 1'b0;
        slow_rst_n = 1'b0;
        repeat (4) @(negedge slow_clk);
        @(negedge bus_clk) bus_rst_n = 1'b1;
        @(negedge slow_clk) slow_rst_n = 1'b1;
    endtask

    task automatic bus_cmd(input logic [15:0] key);
        @(negedge bus_clk) begin cmd_we = 1'b1; cmd_key = key; end
        @(negedge bus_clk) cmd_we = 1'b0;
    endtask

    task automatic bus_div(input logic [2:0] code);
        @(negedge bus_clk) begin div_we = 1'b1; div_wdata = code; end
        @(negedge bus_clk) div_we = 1'b0;
    endtask

    task automatic bus_rld(input logic [11:0] val);
        @(negedge bus_clk) begin rld_we = 1'b1; rld_wdata = val; end
        @(negedge bus_clk) rld_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && (div_busy || rld_busy); i++) @(negedge bus_clk);
        chk(!div_busy && !rld_busy, "R8 busy clears", int'(div_busy || rld_busy), 0);
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 40000 && !reset_req; i++) @(negedge slow_clk);
        chk(reset_req, "R2 request seen", int'(reset_req), 1);
        chk(wdt_count == 12'd0, "R2 count zero at request", int'(wdt_count), 0);
    endtask

    // at a negedge showing reset_req, count slow cycles to the next request
    task automatic measure(input string req, input int exp);
        int k = 0;
        do begin
            @(negedge slow_clk);
            k++;
            if (k == 1) chk(!reset_req, "R2 one-cycle pulse", int'(reset_req), 0);
        end while (!reset_req && k < 40000);
        chk(k == exp, req, k, exp);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge bus_clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int k;
        bit seen;
        // reset state
        do_reset(1'b0);
        @(negedge slow_clk);
        chk(!wdt_running, "R3 idle after reset", int'(wdt_running), 0);
        chk(wdt_count == 12'hFFF, "R9 count reset", int'(wdt_count), 4095);
        chk(!div_busy && !rld_busy, "R8 busy low after reset", int'(div_busy || rld_busy), 0);
        seen = 0;
        repeat (50) @(negedge slow_clk) if (reset_req) seen = 1;
        chk(wdt_count == 12'hFFF, "R3 counter frozen before start", int'(wdt_count), 4095);
        chk(!seen, "R3 no request before start", int'(seen), 0);

        // locked write is ignored
        bus_rld(12'd9);
        chk(!rld_busy, "R7 locked write ignored", int'(rld_busy), 0);

        // unlock, write, then a write while busy is dropped
        bus_cmd(16'h5555);
        bus_rld(12'd9);
        chk(rld_busy, "R8 busy after accepted write", int'(rld_busy), 1);
        bus_rld(12'd3);
        wait_idle();

        // start
        bus_cmd(16'hCCCC);
        for (int i = 0; i < 50 && !wdt_running; i++) @(negedge slow_clk);
        chk(wdt_running, "R3 started by key", int'(wdt_running), 1);
        chk(wdt_count == 12'd9, "R3 loaded reload value (R7 busy write dropped)", int'(wdt_count), 9);
        wait_pulse();
        measure("R1 R2 period code 0", 10 * 4);

        // sweep the divider codes
        for (int c = 1; c < 8; c++) begin
            bus_cmd(16'h5555);
            bus_div(3'(c));
            chk(div_busy, "R8 div busy after write", int'(div_busy), 1);
            wait_idle();
            bus_cmd(16'h0000);
            bus_rld(12'd1);
            chk(!rld_busy, "R6 other key relocks", int'(rld_busy), 0);
            wait_pulse();
            measure("R1 period for divider code", 10 * ratio_of(c));
        end

        // back to code 0, then feed relocks
        bus_cmd(16'h5555);
        bus_div(3'd0);
        wait_idle();
        bus_cmd(16'hAAAA);
        bus_rld(12'd2);
        chk(!rld_busy, "R5 feed key relocks", int'(rld_busy), 0);

        // feed timing
        for (int i = 0; i < 400 && wdt_count != 12'd5; i++) @(negedge slow_clk);
        chk(wdt_count == 12'd5, "R5 reached mid count", int'(wdt_count), 5);
        bus_cmd(16'hAAAA);
        seen = 0;
        for (int i = 0; i < 400 && wdt_count != 12'd9; i++) begin
            @(negedge slow_clk);
            if (reset_req) seen = 1;
        end
        chk(!seen && wdt_count == 12'd9, "R5 feed reloads before timeout", int'(seen), 0);
        k = 0;
        do begin @(negedge slow_clk); k++; end while (!reset_req && k < 40000);
        chk(k == 9 * 4, "R5 timeout after feed", k, 36);

        // strap start
        do_reset(1'b1);
        for (int i = 0; i < 3 && !wdt_running; i++) @(negedge slow_clk);
        chk(wdt_running, "R4 strap starts", int'(wdt_running), 1);
        chk(wdt_count == 12'hFFF, "R4 strap count 0xFFF", int'(wdt_count), 4095);
        for (int i = 0; i < 40 && wdt_count != 12'hFFE; i++) @(negedge slow_clk);
        k = 0;
        do begin @(negedge slow_clk); k++; end while (wdt_count == 12'hFFE && k < 1000);
        chk(k == 4 && wdt_count == 12'hFFD, "R9 R1 default ratio 4", k, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule